// File: doc/BRIEF.md
# Prioritized Nesting Interrupt Controller

This block sits beside a stack-machine core and decides, on every clock, whether the core must be preempted. Each request line carries its own priority in the range 0 to 99. Requests are captured on their rising edges. The highest eligible pending request is compared with the level the core is running at. If it is strictly higher, the block issues a one-cycle grant that carries the source index as the handler vector. The core uses that pulse to branch at once and to push its interrupted address onto its return stack. No general registers are saved, because the data stack keeps the interrupted operands under the new ones.

The block keeps its own stack of saved running levels, with the same depth as the core's return stack. A return-from-interrupt strobe pops this stack and restores the previous level. A request that lands on the same clock as the return is weighed against the restored level. Two masks are provided. A global disable stops every grant. A threshold mode stops only requests whose priority is below a programmable threshold.

Top module: `irq_nest_ctrl`

## Requirements
- R1: A request line sets its pending bit only on a 0-to-1 transition. The bit stays set until that source is granted. A line held high does not set it again.
- R2: A pending request is granted only if its priority plus one is strictly greater than the running-level code. Equal or lower requests stay pending.
- R3: Among eligible pending requests, the highest priority wins. Ties go to the lowest input index.
- R4: A grant is one cycle of `take_o` high, with `vec_o` equal to the winning source index. It appears on the clock edge after the edge that latched the request, and it clears that source's pending bit.
- R5: On a grant, `lvl_o` becomes the winner's priority plus one, and `depth_o` rises by one. The idle level code is 0.
- R6: A `rti_i` strobe while `depth_o` is nonzero restores `lvl_o` to the code saved at the matching grant, and lowers `depth_o` by one. With `depth_o` at 0 it has no effect.
- R7: A request that is arbitrated on the same edge as `rti_i` is compared with the restored level, not with the level being left.
- R8: While `glob_dis_i` is high, no grant is issued, and pending bits are kept.
- R9: While `thr_en_i` is high, requests with priority below `thr_i` are not granted. Requests at or above `thr_i` are still granted.
- R10: When `depth_o` equals DEPTH and no return happens on the same edge, no grant is issued.
- R11: During and right after reset, `take_o` is 0, `lvl_o` is 0, `depth_o` is 0, and all pending bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_SRC | Request lines, edge-latched |
| prio_i | input | N_SRC*7 | Priority of each source; source i occupies bits [7i+6:7i] |
| glob_dis_i | input | 1 | Blocks all grants |
| thr_en_i | input | 1 | Enables threshold masking |
| thr_i | input | 7 | Lowest priority still allowed when threshold masking is on |
| rti_i | input | 1 | Return-from-interrupt strobe |
| take_o | output | 1 | One-cycle grant: branch and push the return address |
| vec_o | output | IDX_W | Index of the granted source (handler vector) |
| lvl_o | output | 8 | Running-level code: 0 when idle, otherwise priority plus one |
| depth_o | output | SP_W | Current nesting depth |

## Verification
A corrupt pending bit shows up as a grant that should not happen, or as a missing grant, one edge after the disturbing cycle. A wrong entry in the level stack stays hidden until the matching return. Then `lvl_o` takes a wrong value at once, and the next arbitration makes the wrong preemption decision. For this reason the stimulus nests to full depth and unwinds with requests pending on the return edges. A stack-pointer error shows directly in `depth_o`, and later as a full-stack block at the wrong depth.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int PRIO_W   = 7;
  localparam int PRIO_MAX = 99;
  localparam int LVL_W    = PRIO_W + 1;
  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [LVL_W-1:0]  lvl_t;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      pend_o <= '0;
    end else begin
      req_q  <= req_i;
      pend_o <= (pend_o & ~clr_i) | (req_i & ~req_q);
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_nest_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDX_W = 3
) (
  input  logic [N_SRC-1:0]        pend_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  input  logic                    dis_i,
  input  logic                    thr_en_i,
  input  prio_t                   thr_i,
  input  lvl_t                    lvl_i,
  output logic                    hit_o,
  output logic [IDX_W-1:0]        idx_o,
  output lvl_t                    lvl_o
);
  prio_t best;

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    best  = '0;
    for (int i = 0; i < N_SRC; i++) begin
      prio_t p;
      logic  ok;
      p  = prio_i[i*PRIO_W +: PRIO_W];
      ok = pend_i[i] && !dis_i && !(thr_en_i && (p < thr_i)) &&
           (({1'b0, p} + LVL_W'(1)) > lvl_i);
      if (ok && (!hit_o || (p > best))) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
        best  = p;
      end
    end
    lvl_o = {1'b0, best} + LVL_W'(1);
  end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
  import irq_nest_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SP_W  = 4,
  parameter int ADR_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_i,
  input  logic            pop_i,
  input  lvl_t            din_i,
  output lvl_t            top_o,
  output logic [SP_W-1:0] sp_o
);
  lvl_t            mem [DEPTH];
  logic [SP_W-1:0] sp_m1;
  logic [ADR_W-1:0] rd_adr, wr_adr;

  assign sp_m1  = sp_o - SP_W'(1);
  assign rd_adr = sp_m1[ADR_W-1:0];
  assign wr_adr = pop_i ? rd_adr : sp_o[ADR_W-1:0];
  assign top_o  = (sp_o == '0) ? '0 : mem[rd_adr];

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_adr] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst)                  sp_o <= '0;
    else if (push_i && !pop_i) sp_o <= sp_o + SP_W'(1);
    else if (pop_i && !push_i) sp_o <= sp_m1;
  end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int DEPTH = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int SP_W  = $clog2(DEPTH + 1),
  localparam int ADR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_SRC-1:0]        req_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  input  logic                    glob_dis_i,
  input  logic                    thr_en_i,
  input  logic [PRIO_W-1:0]       thr_i,
  input  logic                    rti_i,
  output logic                    take_o,
  output logic [IDX_W-1:0]        vec_o,
  output logic [LVL_W-1:0]        lvl_o,
  output logic [SP_W-1:0]         depth_o
);
  logic [N_SRC-1:0] pend, clr;
  logic             hit, pop, room, grant;
  logic [IDX_W-1:0] win_idx;
  lvl_t             win_lvl, top_lvl, lvl_eff;

  irq_edge_latch #(.N_SRC(N_SRC)) u_latch (
    .clk(clk), .rst(rst), .req_i(req_i), .clr_i(clr), .pend_o(pend)
  );

  assign pop     = rti_i && (depth_o != '0);
  assign lvl_eff = pop ? top_lvl : lvl_o;

  irq_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
    .pend_i(pend), .prio_i(prio_i), .dis_i(glob_dis_i),
    .thr_en_i(thr_en_i), .thr_i(thr_i), .lvl_i(lvl_eff),
    .hit_o(hit), .idx_o(win_idx), .lvl_o(win_lvl)
  );

  assign room  = pop || (depth_o < SP_W'(DEPTH));
  assign grant = hit && room;

  generate
    for (genvar g = 0; g < N_SRC; g++) begin : g_clr
      assign clr[g] = grant && (win_idx == IDX_W'(g));
    end
  endgenerate

  irq_lvl_stack #(.DEPTH(DEPTH), .SP_W(SP_W), .ADR_W(ADR_W)) u_stack (
    .clk(clk), .rst(rst), .push_i(grant), .pop_i(pop),
    .din_i(lvl_eff), .top_o(top_lvl), .sp_o(depth_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o <= 1'b0;
      vec_o  <= '0;
      lvl_o  <= '0;
    end else begin
      take_o <= grant;
      lvl_o  <= grant ? win_lvl : lvl_eff;
      if (grant) vec_o <= win_idx;
    end
  end
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 8,
  parameter int SP_W  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             glob_dis_i,
  input logic             rti_i,
  input logic             take_o,
  input logic [LVL_W-1:0] lvl_o,
  input logic [SP_W-1:0]  depth_o
);
  p_disable_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    $past(glob_dis_i) |-> !take_o);

  p_depth_bound_r10: assert property (@(posedge clk) disable iff (rst)
    int'(depth_o) <= DEPTH);

  p_full_blocks_r10: assert property (@(posedge clk) disable iff (rst)
    (take_o && !$past(rti_i)) |-> (int'($past(depth_o)) < DEPTH));

  p_grant_nests_r5: assert property (@(posedge clk) disable iff (rst)
    take_o |-> ((lvl_o != '0) && (depth_o != '0)));

  p_idle_level_r6: assert property (@(posedge clk) disable iff (rst)
    (depth_o == '0) |-> (lvl_o == '0));

  p_return_pops_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(rti_i) && !take_o && ($past(depth_o) != '0)) |->
      (int'(depth_o) == int'($past(depth_o)) - 1));

  p_depth_step_r5: assert property (@(posedge clk) disable iff (rst)
    (int'(depth_o) <= int'($past(depth_o)) + 1) &&
    (int'(depth_o) >= int'($past(depth_o)) - 1));
endmodule

bind irq_nest_ctrl irq_nest_chk #(.DEPTH(DEPTH), .LVL_W(irq_nest_pkg::LVL_W), .SP_W(SP_W)) u_chk (
  .clk(clk), .rst(rst), .glob_dis_i(glob_dis_i), .rti_i(rti_i),
  .take_o(take_o), .lvl_o(lvl_o), .depth_o(depth_o)
);

// File: tb/irq_nest_ctrl_test.sv
`timescale 1ns/1ps
module irq_nest_ctrl_test;
  localparam int N = 4;
  localparam int D = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req = '0;
  logic [27:0] prio = {7'd90, 7'd50, 7'd50, 7'd10};
  logic       dis = 1'b0, ten = 1'b0, rti = 1'b0;
  logic [6:0] thr = '0;
  logic       take;
  logic [1:0] vec;
  logic [7:0] lvl;
  logic [1:0] dep;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_nest_ctrl #(.N_SRC(N), .DEPTH(D)) uut (
    .clk(clk), .rst(rst), .req_i(req), .prio_i(prio), .glob_dis_i(dis),
    .thr_en_i(ten), .thr_i(thr), .rti_i(rti),
    .take_o(take), .vec_o(vec), .lvl_o(lvl), .depth_o(dep)
  );

  typedef struct packed {
    logic [3:0] req; logic dis; logic ten; logic [6:0] thr; logic rti;
    logic take; logic [1:0] vec; logic [7:0] lvl; logic [1:0] dep;
    logic [3:0] rq;
  } row_t;

  // Priorities: src0=10, src1=50, src2=50, src3=90; DEPTH=2.
  localparam row_t TBL [22] = '{
    '{4'b0001,0,0,7'd0, 0, 0,2'd0, 8'd0, 2'd0, 4'd1},
    '{4'b0000,0,0,7'd0, 0, 1,2'd0, 8'd11,2'd1, 4'd4},
    '{4'b0110,0,0,7'd0, 0, 0,2'd0, 8'd11,2'd1, 4'd1},
    '{4'b0000,0,0,7'd0, 0, 1,2'd1, 8'd51,2'd2, 4'd3},
    '{4'b0000,0,0,7'd0, 0, 0,2'd0, 8'd51,2'd2, 4'd2},
    '{4'b1000,0,0,7'd0, 0, 0,2'd0, 8'd51,2'd2, 4'd1},
    '{4'b0000,0,0,7'd0, 0, 0,2'd0, 8'd51,2'd2, 4'd10},
    '{4'b0000,0,0,7'd0, 1, 1,2'd3, 8'd91,2'd2, 4'd7},
    '{4'b0000,0,0,7'd0, 1, 1,2'd2, 8'd51,2'd2, 4'd7},
    '{4'b0000,0,0,7'd0, 1, 0,2'd0, 8'd11,2'd1, 4'd6},
    '{4'b0000,0,0,7'd0, 1, 0,2'd0, 8'd0, 2'd0, 4'd6},
    '{4'b0001,1,0,7'd0, 0, 0,2'd0, 8'd0, 2'd0, 4'd8},
    '{4'b0000,1,0,7'd0, 0, 0,2'd0, 8'd0, 2'd0, 4'd8},
    '{4'b0000,0,1,7'd20,0, 0,2'd0, 8'd0, 2'd0, 4'd9},
    '{4'b0010,0,1,7'd20,0, 0,2'd0, 8'd0, 2'd0, 4'd9},
    '{4'b0000,0,1,7'd20,0, 1,2'd1, 8'd51,2'd1, 4'd9},
    '{4'b0000,0,0,7'd0, 0, 0,2'd0, 8'd51,2'd1, 4'd2},
    '{4'b0000,0,0,7'd0, 1, 1,2'd0, 8'd11,2'd1, 4'd7},
    '{4'b0000,0,0,7'd0, 1, 0,2'd0, 8'd0, 2'd0, 4'd6},
    '{4'b0001,0,0,7'd0, 0, 0,2'd0, 8'd0, 2'd0, 4'd1},
    '{4'b0001,0,0,7'd0, 0, 1,2'd0, 8'd11,2'd1, 4'd5},
    '{4'b0001,0,0,7'd0, 1, 0,2'd0, 8'd0, 2'd0, 4'd1}
  };

  function automatic string tag(input logic [3:0] r);
    case (r)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string rq);
    chk(rq, "take", int'(take), 0);
    chk(rq, "lvl",  int'(lvl),  0);
    chk(rq, "depth", int'(dep), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_idle("R11");
    rst = 1'b0;
    for (int k = 0; k < 22; k++) begin
      req = TBL[k].req; dis = TBL[k].dis; ten = TBL[k].ten;
      thr = TBL[k].thr; rti = TBL[k].rti;
      @(negedge clk);
      chk(tag(TBL[k].rq), $sformatf("row %0d take", k), int'(take), int'(TBL[k].take));
      chk(tag(TBL[k].rq), $sformatf("row %0d lvl", k), int'(lvl), int'(TBL[k].lvl));
      chk(tag(TBL[k].rq), $sformatf("row %0d depth", k), int'(dep), int'(TBL[k].dep));
      if (TBL[k].take)
        chk(tag(TBL[k].rq), $sformatf("row %0d vec", k), int'(vec), int'(TBL[k].vec));
    end
    // R6: return with nothing nested has no effect
    req = '0; rti = 1'b0;
    @(negedge clk);
    rti = 1'b1;
    @(negedge clk);
    rti = 1'b0;
    chk_idle("R6");
    // R11: reset in the middle of a pending and nested state
    req = 4'b1000;
    @(negedge clk);
    req = 4'b0100;
    @(negedge clk);
    chk("R4", "take before reset", int'(take), 1);
    rst = 1'b1;
    @(negedge clk);
    chk_idle("R11");
    rst = 1'b0; req = '0;
    @(negedge clk);
    @(negedge clk);
    chk_idle("R11");
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R11 watchdog: got %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule